// File: doc/BRIEF.md
# Programmable Output Divider with Test Selector

This block sits behind a synthesizer's oscillator and turns its fast clock into the delivered output clock. The output is divided by a power of two between 2 and 16, chosen by a 2-bit code. It has a 50% duty cycle and an output enable that never truncates a pulse. Two other counters live alongside it. The first is a 9-bit feedback (loop) counter that produces one narrow pulse every M oscillator periods. The second is a divide-by-8 stage for the reference clock. A 3-bit test code picks what appears on a single observation pin.

All clocks are modelled as enable strobes inside one simulation clock domain: `vco_tick`, `ref_tick` and `byp_tick` each mark one period of the corresponding source. One test code reroutes the slow external bypass strobe into both the output divider and the loop counter. It also exposes the loop counter on the test pin, which allows low-speed board debug without the oscillator.

Top module: `synth_outdiv`

## Requirements
- R1: With the output enabled, `clk_out` has a period of 2, 4, 8 or 16 source ticks for `n_code` 00, 01, 10 or 11. It is high for exactly half of each period and changes only on a source tick.
- R2: `out_en` is sampled only at the start of an output period. Dropping it mid-pulse lets the current high phase finish at full length and then holds `clk_out` low. Raising it again resumes with a full-length high phase, and `clk_out` never rises unless `out_en` was high in the cycle before.
- R3: With test code 010, `test_out` shows the reference divided by 8: a period of 8 `ref_tick` pulses, high for 4 of them.
- R4: A change of `n_code` takes effect only after the current full output period (high plus low phase) has completed.
- R5: Test code 001 drives `test_out` high, 101 drives it low, and 000 passes `shift_bit` straight through.
- R6: With test code 011, `test_out` shows the loop counter: a period of M source ticks, high for one tick. An M of 0 or 1 acts as 1, so the output stays high.
- R7: Test code 110 (bypass) makes `byp_tick` the source for both the output divider and the loop counter, and `vco_tick` is then ignored. `test_out` carries the loop counter output.
- R8: Test code 100 puts the main output on `test_out`. Test code 111 puts the main output divided by 4 on `test_out`, with a 50% duty cycle.
- R9: While reset is asserted and for the synchronizer delay after its release, `clk_out` and the divided reference are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock shared by all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One pulse per oscillator period |
| ref_tick | input | 1 | One pulse per reference period |
| byp_tick | input | 1 | One pulse per external bypass clock period |
| m_val | input | 9 | Loop counter modulus |
| n_code | input | 2 | Output divide code |
| t_code | input | 3 | Test output selector |
| out_en | input | 1 | Output enable, active high |
| shift_bit | input | 1 | Serial shift-out bit for test code 000 |
| clk_out | output | 1 | Divided main output clock |
| test_out | output | 1 | Selected observation signal |

## Verification
Source strobes arrive at random gaps, and the bench counts ticks rather than cycles. A divider that wrongly counts simulation cycles, or that uses the wrong source, therefore shows up as a period mismatch. Random divide codes and loop moduli in the lock range test the period arithmetic, and directed runs cover the degenerate moduli 0 and 1. For bypass, the oscillator strobe is held on every cycle while the bypass strobe is random, so the measured periods show which source is actually in use. Enable and divide-code changes are made in the middle of a high phase, which shows whether a pulse gets cut short or a period gets split.

// File: rtl/synth_outdiv_pkg.sv
package synth_outdiv_pkg;

  typedef enum logic [2:0] {
    TSEL_SHIFT   = 3'b000,
    TSEL_HIGH    = 3'b001,
    TSEL_REF     = 3'b010,
    TSEL_LOOP    = 3'b011,
    TSEL_MAIN    = 3'b100,
    TSEL_LOW     = 3'b101,
    TSEL_BYPASS  = 3'b110,
    TSEL_QUARTER = 3'b111
  } tsel_e;

endpackage

// File: rtl/outdiv_core.sv
module outdiv_core #(
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [N_W-1:0] n_code,
  input  logic           out_en,
  output logic           clk_o,
  output logic           rise_o
);
  localparam int HALF_MAX = 1 << ((1 << N_W) - 1);
  localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ph_q, ph_d;
  logic           en_q, en_d;
  logic [N_W-1:0] nact_q, nact_d;
  logic [CW-1:0]  half_m1;
  logic           wrap;

  assign half_m1 = CW'((32'd1 << nact_q) - 32'd1);
  assign wrap    = tick && (cnt_q == half_m1);

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    en_d   = en_q;
    nact_d = nact_q;
    if (tick) begin
      if (wrap) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
        if (!ph_q) begin
          en_d   = out_en;
          nact_d = n_code;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      en_q   <= 1'b0;
      nact_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      en_q   <= en_d;
      nact_q <= nact_d;
    end
  end

  assign clk_o  = ph_q & en_q;
  assign rise_o = wrap && !ph_q && out_en;
endmodule

// File: rtl/loop_counter.sv
module loop_counter #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [M_W-1:0] m_val,
  output logic           pulse_o
);
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           pls_q, pls_d;
  logic [M_W-1:0] m_eff;

  assign m_eff = (m_val <= M_W'(1)) ? M_W'(1) : m_val;

  always_comb begin
    cnt_d = cnt_q;
    pls_d = pls_q;
    if (tick) begin
      if (cnt_q <= M_W'(1)) begin
        cnt_d = m_eff;
        pls_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
        pls_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign pulse_o = pls_q;
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic div_o
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign div_o = cnt_q[DIV_LOG2-1];
endmodule

// File: rtl/synth_outdiv.sv
module synth_outdiv
  import synth_outdiv_pkg::*;
#(
  parameter int N_W       = 2,
  parameter int M_W       = 9,
  parameter int RDIV_LOG2 = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_tick,
  input  logic           ref_tick,
  input  logic           byp_tick,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_code,
  input  logic [2:0]     t_code,
  input  logic           out_en,
  input  logic           shift_bit,
  output logic           clk_out,
  output logic           test_out
);
  localparam int QW = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_q;
  logic          bypass;
  logic          src_tick;
  logic          main_rise;
  logic          loop_pulse;
  logic          ref_div;
  logic [QW-1:0] quart_q, quart_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign bypass   = (tsel_e'(t_code) == TSEL_BYPASS);
  assign src_tick = bypass ? byp_tick : vco_tick;

  outdiv_core #(.N_W(N_W)) u_odiv (
    .clk    (clk),
    .rst_n  (rst_q),
    .tick   (src_tick),
    .n_code (n_code),
    .out_en (out_en),
    .clk_o  (clk_out),
    .rise_o (main_rise)
  );

  loop_counter #(.M_W(M_W)) u_loop (
    .clk     (clk),
    .rst_n   (rst_q),
    .tick    (src_tick),
    .m_val   (m_val),
    .pulse_o (loop_pulse)
  );

  ref_divider #(.DIV_LOG2(RDIV_LOG2)) u_ref (
    .clk   (clk),
    .rst_n (rst_q),
    .tick  (ref_tick),
    .div_o (ref_div)
  );

  always_comb begin
    quart_d = quart_q;
    if (main_rise) quart_d = quart_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) quart_q <= '0;
    else        quart_q <= quart_d;
  end

  always_comb begin
    case (tsel_e'(t_code))
      TSEL_SHIFT:   test_out = shift_bit;
      TSEL_HIGH:    test_out = 1'b1;
      TSEL_REF:     test_out = ref_div;
      TSEL_LOOP:    test_out = loop_pulse;
      TSEL_MAIN:    test_out = clk_out;
      TSEL_LOW:     test_out = 1'b0;
      TSEL_BYPASS:  test_out = loop_pulse;
      default:      test_out = quart_q[QW-1];
    endcase
  end
endmodule

// File: rtl/synth_outdiv_chk.sv
module synth_outdiv_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       clk_out,
  input logic       out_en,
  input logic       ref_tick,
  input logic       byp_tick,
  input logic [2:0] t_code,
  input logic       src_tick,
  input logic       loop_pulse,
  input logic       ref_div
);
  p_out_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(clk_out) |-> $past(src_tick));

  p_rise_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(clk_out) |-> $past(out_en));

  p_ref_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(ref_div) |-> $past(ref_tick));

  p_loop_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(loop_pulse) |-> $past(src_tick));

  p_bypass_src_r7: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(t_code) == 3'b110 && !$stable(loop_pulse)) |-> $past(byp_tick));
endmodule

bind synth_outdiv synth_outdiv_chk u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .clk_out    (clk_out),
  .out_en     (out_en),
  .ref_tick   (ref_tick),
  .byp_tick   (byp_tick),
  .t_code     (t_code),
  .src_tick   (src_tick),
  .loop_pulse (loop_pulse),
  .ref_div    (ref_div)
);

// File: tb/synth_outdiv_tb.sv
module synth_outdiv_tb;
  logic       clk;
  logic       rst_n;
  logic       vco_tick, ref_tick, byp_tick;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_code;
  logic       out_en, shift_bit;
  logic       clk_out, test_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  synth_outdiv u_dut (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .byp_tick(byp_tick), .m_val(m_val), .n_code(n_code), .t_code(t_code),
    .out_en(out_en), .shift_bit(shift_bit), .clk_out(clk_out), .test_out(test_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_per(input int n);
    return 2 << n;
  endfunction

  function automatic int exp_loop(input int m);
    return (m <= 1) ? 1 : m;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic tick_of(input int src);
    case (src)
      0: return vco_tick;
      1: return ref_tick;
      default: return byp_tick;
    endcase
  endfunction

  task automatic drive_tick(input int src);
    vco_tick = 1'b0; ref_tick = 1'b0; byp_tick = 1'b0;
    case (src)
      0: vco_tick = 1'($urandom % 2);
      1: ref_tick = 1'($urandom % 2);
      default: begin byp_tick = 1'($urandom % 2); vco_tick = 1'b1; end
    endcase
  endtask

  // Counts source ticks between edges; skips two rises to settle.
  task automatic measure(input bit use_test, input int src, output int hi, output int per);
    int t = 0;
    int rises = 0;
    int t1 = 0;
    int t2 = 0;
    logic s, prev;
    hi = -1; per = -1;
    prev = use_test ? test_out : clk_out;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      t += int'(tick_of(src));
      s = use_test ? test_out : clk_out;
      if (s && !prev) begin
        rises++;
        if (rises == 3) t1 = t;
        if (rises == 4) begin per = t - t1; hi = t2 - t1; break; end
      end
      if (!s && prev && rises == 3) t2 = t;
      prev = s;
      drive_tick(src);
    end
    vco_tick = 1'b0; ref_tick = 1'b0; byp_tick = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_out;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (clk_out && !prev) break;
      prev = clk_out;
    end
  endtask

  task automatic run_len(output int len);
    logic v;
    v = clk_out;
    len = 1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (clk_out == v) len++;
      else break;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, per, a, b, c, d, n, m, highs;
    void'($urandom(32'd2024));
    rst_n = 1'b0; vco_tick = 0; ref_tick = 0; byp_tick = 0;
    m_val = 9'd5; n_code = 2'd0; t_code = 3'b010; out_en = 1'b1; shift_bit = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 reset clk_out", int'(clk_out), 0);
    check("R9 reset ref div", int'(test_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 constants and passthrough
    t_code = 3'b001; #1 check("R5 code001 high", int'(test_out), 1);
    t_code = 3'b101; #1 check("R5 code101 low", int'(test_out), 0);
    t_code = 3'b000; shift_bit = 1'b1; #1 check("R5 shift bit 1", int'(test_out), 1);
    shift_bit = 1'b0; #1 check("R5 shift bit 0", int'(test_out), 0);

    // R1 every divide code with random tick gaps
    t_code = 3'b100;
    for (int k = 0; k < 4; k++) begin
      n_code = 2'(k);
      measure(0, 0, hi, per);
      check($sformatf("R1 period n=%0d", k), per, exp_per(k));
      check($sformatf("R1 high n=%0d", k), hi, exp_per(k) / 2);
    end

    // R8 main output on test pin, random codes
    for (int k = 0; k < 3; k++) begin
      n = int'($urandom % 4);
      n_code = 2'(n);
      measure(1, 0, hi, per);
      check($sformatf("R8 main on test n=%0d", n), per, exp_per(n));
    end
    t_code = 3'b111; n_code = 2'd1;
    measure(1, 0, hi, per);
    check("R8 quarter period", per, 4 * exp_per(1));
    check("R8 quarter high", hi, 2 * exp_per(1));

    // R3 reference divider
    t_code = 3'b010;
    measure(1, 1, hi, per);
    check("R3 ref period", per, 8);
    check("R3 ref high", hi, 4);

    // R6 loop counter: random lock-range moduli and a small one
    t_code = 3'b011;
    for (int k = 0; k < 3; k++) begin
      m = (k == 2) ? 5 : 200 + int'($urandom % 201);
      m_val = 9'(m);
      measure(1, 0, hi, per);
      check($sformatf("R6 loop period m=%0d", m), per, exp_loop(m));
      check($sformatf("R6 loop high m=%0d", m), hi, 1);
    end
    for (int k = 0; k < 2; k++) begin
      m_val = 9'(k);
      vco_tick = 1'b1;
      repeat (6) @(negedge clk);
      highs = 0;
      repeat (20) begin @(negedge clk); highs += int'(test_out); end
      check($sformatf("R6 degenerate m=%0d stays high", k), highs, 20);
      vco_tick = 1'b0;
    end

    // R7 bypass: vco held active, bypass strobes random
    t_code = 3'b110; m_val = 9'd7; n_code = 2'd1;
    measure(1, 2, hi, per);
    check("R7 bypass loop period", per, 7);
    check("R7 bypass loop high", hi, 1);
    measure(0, 2, hi, per);
    check("R7 bypass main period", per, exp_per(1));

    // R2 enable dropped mid pulse, then restored
    t_code = 3'b100; n_code = 2'd3; out_en = 1'b1; vco_tick = 1'b1;
    repeat (40) @(negedge clk);
    wait_rise();
    repeat (2) @(negedge clk);
    out_en = 1'b0;
    run_len(a);
    check("R2 pulse finishes after disable", a, 6);
    highs = 0;
    repeat (48) begin @(negedge clk); highs += int'(clk_out); end
    check("R2 held low while disabled", highs, 0);
    out_en = 1'b1;
    wait_rise();
    run_len(a);
    check("R2 first pulse after enable full", a, 8);

    // R4 divide code change mid period
    wait_rise();
    repeat (2) @(negedge clk);
    n_code = 2'd0;
    run_len(a); run_len(b); run_len(c); run_len(d);
    check("R4 old high kept", a, 6);
    check("R4 old low kept", b, 8);
    check("R4 new high", c, 1);
    check("R4 new low", d, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule